// File: doc/BRIEF.md
# Core-Local Register File with Shadowed Special Registers

This block is the private word store of one processor core. It holds 512 words of 32 bits. Each word may hold an instruction or a datum, and the core reaches it only by whole-word address. The top sixteen addresses (496 to 511) are overlaid by special function registers. Whether a port sees the special register or the RAM word stored beneath it depends on which port makes the access. The source-operand port sees live values. The destination-operand port and the instruction-fetch port see the shadow RAM.

Among the specials, offsets 0 to 7 (addresses 496 to 503) are read-only: offset 0 is the live input-pin sample, offset 1 is a free-running cycle counter, and offsets 2 to 7 read as zero. Offsets 8 to 15 (addresses 504 to 511) are read-write control registers that drive the `spr_out` bus. Their values can never be read back as operands. A destination write to one of them updates both the register and its shadow word.

When a core starts, a loader port fills the general area. After a start strobe it takes one word per valid beat, writes the words to addresses 0 to 495 in increasing order, and then pulses a done flag. While the load runs, writes from the core side are blocked.

Top module: `shadow_regfile`

## Requirements
- R1: A destination write to any address is visible from the next cycle on the fetch port (all addresses) and on the source and destination ports for addresses 0 to 495, so a stored datum can later be fetched as an instruction.
- R2: A read of an address in the same cycle as a write to it returns the old word; the new word appears in the following cycle.
- R3: A source read of address 496 returns `pins_in` combinationally, in the same cycle.
- R4: A source read of address 497 returns a counter that is 0 in reset, increments by one every clock after reset, and wraps modulo 2^32.
- R5: A source read of addresses 498 to 503 or 504 to 511 returns zero.
- R6: A destination read or a fetch of addresses 496 to 503 returns the shadow word last written there by the destination port, not the special value.
- R7: A destination write to address 504+k (k = 0..7) sets `spr_out[32k+31:32k]` and the shadow word together. The shadow word is then visible only through fetch; a destination read of 504 to 511 returns zero.
- R8: After a one-cycle `ld_start`, `ld_busy` is high and each cycle with `ld_valid` high writes `ld_data` to the next address, starting at 0. The beat for address 495 ends the load: in the next cycle `ld_busy` is low and `ld_done` is high for exactly one cycle.
- R9: While `ld_busy` is high, core writes (`wr_en`) change neither the RAM nor `spr_out`.
- R10: `ld_valid` outside a load has no effect, and the loader never writes addresses 496 to 511.
- R11: In reset, `spr_out` is zero and `ld_busy` and `ld_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_addr | input | 9 | Source-operand read address |
| src_data | output | 32 | Source-operand read data |
| dst_addr | input | 9 | Destination-operand read address |
| dst_data | output | 32 | Destination-operand read data |
| fetch_addr | input | 9 | Instruction-fetch read address |
| fetch_data | output | 32 | Instruction-fetch read data |
| wr_en | input | 1 | Destination write enable |
| wr_addr | input | 9 | Destination write address |
| wr_data | input | 32 | Destination write data |
| ld_start | input | 1 | Start of a core load |
| ld_valid | input | 1 | Loader word valid |
| ld_data | input | 32 | Loader word |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle pulse at the end of a load |
| pins_in | input | 32 | Live input-pin sample |
| spr_out | output | 256 | Eight read-write control registers, register k in bits 32k+31:32k |

## Verification
The condition hardest to create from the ports is one in which the shadow word beneath a special address and the special value itself are both known and differ. This takes a destination write to the special address, followed by reads of that same address on all three ports while `pins_in` is driven to a different value. The bench does this directly for every special address. A random phase then mixes writes with reads on three independent addresses each cycle. Loads are run with random gaps between beats, and core writes to general and control addresses are attempted during those gaps.

// File: rtl/shrf_pkg.sv
package shrf_pkg;

   typedef enum logic [1:0] {
      REG_GENERAL,
      REG_SPR_RO,
      REG_SPR_RW
   } region_e;

   typedef enum logic [1:0] {
      PORT_SRC,
      PORT_DST,
      PORT_FETCH
   } port_e;

   typedef enum logic {
      LD_IDLE,
      LD_FILL
   } load_state_e;

   // Map a word address onto its region of the register file.
   function automatic region_e classify(input int unsigned addr,
                                        input int unsigned gp_words,
                                        input int unsigned ro_count);
      if (addr < gp_words) return REG_GENERAL;
      if ((addr - gp_words) < ro_count) return REG_SPR_RO;
      return REG_SPR_RW;
   endfunction

endpackage

// File: rtl/shrf_ram.sv
module shrf_ram #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 512,
   parameter int NUM_RD = 3,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_RD*ADDR_W-1:0] raddr_flat,
   output logic [NUM_RD*DATA_W-1:0] rdata_flat
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Asynchronous read ports: one per consumer, all see pre-write data.
   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rdata_flat[p*DATA_W +: DATA_W] = mem[raddr_flat[p*ADDR_W +: ADDR_W]];
   end

endmodule

// File: rtl/shrf_spr_bank.sv
module shrf_spr_bank #(
   parameter int DATA_W    = 32,
   parameter int SPR_COUNT = 16,
   parameter int RO_COUNT  = 8,
   localparam int IDX_W    = $clog2(SPR_COUNT),
   localparam int RW_COUNT = SPR_COUNT - RO_COUNT
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [DATA_W-1:0]          pins_in,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [DATA_W-1:0]          rd_data,
   output logic [RW_COUNT*DATA_W-1:0] rw_flat
);

   logic [DATA_W-1:0] cycle_cnt;
   logic [DATA_W-1:0] live [SPR_COUNT];

   always_ff @(posedge clk) begin
      if (!rst_n) cycle_cnt <= '0;
      else        cycle_cnt <= cycle_cnt + DATA_W'(1);
   end

   for (genvar i = 0; i < SPR_COUNT; i++) begin : g_spr
      if (i == 0) begin : g_pins
         assign live[i] = pins_in;
      end else if (i == 1) begin : g_cnt
         assign live[i] = cycle_cnt;
      end else if (i < RO_COUNT) begin : g_spare
         assign live[i] = '0;
      end else begin : g_rw
         logic [DATA_W-1:0] ctl_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                             ctl_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))  ctl_q <= wr_data;
         end
         assign live[i] = ctl_q;
         assign rw_flat[(i-RO_COUNT)*DATA_W +: DATA_W] = ctl_q;
      end
   end

   assign rd_data = live[rd_idx];

endmodule

// File: rtl/shrf_loader.sv
module shrf_loader
   import shrf_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int DATA_W     = 32,
   parameter int LOAD_WORDS = 496
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              valid,
   input  logic [DATA_W-1:0] data,
   output logic              busy,
   output logic              done,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [DATA_W-1:0] wdata
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(LOAD_WORDS - 1);

   load_state_e       state;
   logic [ADDR_W-1:0] next_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= LD_IDLE;
         next_addr <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            LD_IDLE: begin
               if (start) begin
                  state     <= LD_FILL;
                  next_addr <= '0;
               end
            end
            LD_FILL: begin
               if (valid) begin
                  if (next_addr == LAST_ADDR) begin
                     state <= LD_IDLE;
                     done  <= 1'b1;
                  end else begin
                     next_addr <= next_addr + ADDR_W'(1);
                  end
               end
            end
            default: state <= LD_IDLE;
         endcase
      end
   end

   assign busy  = (state == LD_FILL);
   assign we    = busy && valid;
   assign waddr = next_addr;
   assign wdata = data;

endmodule

// File: rtl/shrf_port_view.sv
module shrf_port_view
   import shrf_pkg::*;
#(
   parameter port_e VIEW     = PORT_SRC,
   parameter int    ADDR_W   = 9,
   parameter int    DATA_W   = 32,
   parameter int    GP_WORDS = 496,
   parameter int    RO_COUNT = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ram_word,
   input  logic [DATA_W-1:0] spr_live,
   output logic [DATA_W-1:0] data
);

   if (VIEW == PORT_FETCH) begin : g_fetch
      // Fetch always executes the shadow word.
      logic unused_fetch;
      assign unused_fetch = ^{addr, spr_live};
      assign data = ram_word;
   end else if (VIEW == PORT_DST) begin : g_dst
      region_e kind;
      logic    unused_dst;
      assign unused_dst = ^spr_live;
      assign kind = classify(32'(addr), GP_WORDS, RO_COUNT);
      always_comb begin
         data = (kind == REG_SPR_RW) ? '0 : ram_word;
      end
   end else begin : g_src
      region_e kind;
      assign kind = classify(32'(addr), GP_WORDS, RO_COUNT);
      always_comb begin
         case (kind)
            REG_GENERAL: data = ram_word;
            REG_SPR_RO:  data = spr_live;
            default:     data = '0;
         endcase
      end
   end

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 512,
   parameter int SPR_COUNT = 16,
   parameter int RO_COUNT  = 8,
   localparam int ADDR_W   = $clog2(DEPTH),
   localparam int IDX_W    = $clog2(SPR_COUNT),
   localparam int GP_WORDS = DEPTH - SPR_COUNT,
   localparam int RW_COUNT = SPR_COUNT - RO_COUNT
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          src_addr,
   output logic [DATA_W-1:0]          src_data,
   input  logic [ADDR_W-1:0]          dst_addr,
   output logic [DATA_W-1:0]          dst_data,
   input  logic [ADDR_W-1:0]          fetch_addr,
   output logic [DATA_W-1:0]          fetch_data,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       ld_start,
   input  logic                       ld_valid,
   input  logic [DATA_W-1:0]          ld_data,
   output logic                       ld_busy,
   output logic                       ld_done,
   input  logic [DATA_W-1:0]          pins_in,
   output logic [RW_COUNT*DATA_W-1:0] spr_out
);

   import shrf_pkg::*;

   // Elaboration-time parameter checks.
   if (RO_COUNT < 2 || RO_COUNT >= SPR_COUNT) begin : g_bad_ro
      $error("RO_COUNT must leave room for pins, counter and one control register");
   end
   if (SPR_COUNT >= DEPTH || (DEPTH % SPR_COUNT) != 0 ||
       (SPR_COUNT & (SPR_COUNT - 1)) != 0) begin : g_bad_spr
      $error("SPR_COUNT must be a power of two dividing DEPTH");
   end
   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W too small");
   end

   // Write arbitration: the loader owns the array while it runs.
   logic              ldr_we;
   logic [ADDR_W-1:0] ldr_waddr;
   logic [DATA_W-1:0] ldr_wdata;
   logic              core_we;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_waddr;
   logic [DATA_W-1:0] ram_wdata;
   logic              spr_we;

   shrf_loader #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .LOAD_WORDS (GP_WORDS)
   ) u_loader (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ld_start),
      .valid (ld_valid),
      .data  (ld_data),
      .busy  (ld_busy),
      .done  (ld_done),
      .we    (ldr_we),
      .waddr (ldr_waddr),
      .wdata (ldr_wdata)
   );

   assign core_we   = wr_en && !ld_busy;
   assign ram_we    = ldr_we || core_we;
   assign ram_waddr = ldr_we ? ldr_waddr : wr_addr;
   assign ram_wdata = ldr_we ? ldr_wdata : wr_data;
   assign spr_we    = core_we && (wr_addr >= ADDR_W'(GP_WORDS));

   // Shadow array with three read ports: 0 source, 1 destination, 2 fetch.
   localparam int NUM_RD = 3;
   logic [NUM_RD*ADDR_W-1:0] raddr_flat;
   logic [NUM_RD*DATA_W-1:0] rdata_flat;

   assign raddr_flat = {fetch_addr, dst_addr, src_addr};

   shrf_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .NUM_RD (NUM_RD)
   ) u_ram (
      .clk        (clk),
      .we         (ram_we),
      .waddr      (ram_waddr),
      .wdata      (ram_wdata),
      .raddr_flat (raddr_flat),
      .rdata_flat (rdata_flat)
   );

   // Special register bank, read by the source port only.
   logic [DATA_W-1:0] spr_live;

   shrf_spr_bank #(
      .DATA_W    (DATA_W),
      .SPR_COUNT (SPR_COUNT),
      .RO_COUNT  (RO_COUNT)
   ) u_spr (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_in (pins_in),
      .wr_en   (spr_we),
      .wr_idx  (wr_addr[IDX_W-1:0]),
      .wr_data (wr_data),
      .rd_idx  (src_addr[IDX_W-1:0]),
      .rd_data (spr_live),
      .rw_flat (spr_out)
   );

   // Per-port resolution between shadow word and special value.
   localparam port_e VIEWS [NUM_RD] = '{PORT_SRC, PORT_DST, PORT_FETCH};
   logic [NUM_RD*DATA_W-1:0] view_flat;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_view
      shrf_port_view #(
         .VIEW     (VIEWS[p]),
         .ADDR_W   (ADDR_W),
         .DATA_W   (DATA_W),
         .GP_WORDS (GP_WORDS),
         .RO_COUNT (RO_COUNT)
      ) u_view (
         .addr     (raddr_flat[p*ADDR_W +: ADDR_W]),
         .ram_word (rdata_flat[p*DATA_W +: DATA_W]),
         .spr_live (spr_live),
         .data     (view_flat[p*DATA_W +: DATA_W])
      );
   end

   assign src_data   = view_flat[0*DATA_W +: DATA_W];
   assign dst_data   = view_flat[1*DATA_W +: DATA_W];
   assign fetch_data = view_flat[2*DATA_W +: DATA_W];

endmodule

// File: rtl/shadow_regfile_chk.sv
module shadow_regfile_chk #(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 512,
   parameter int SPR_COUNT = 16,
   parameter int RO_COUNT  = 8,
   localparam int ADDR_W   = $clog2(DEPTH),
   localparam int GP_WORDS = DEPTH - SPR_COUNT,
   localparam int RW_COUNT = SPR_COUNT - RO_COUNT
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          src_addr,
   input logic [DATA_W-1:0]          src_data,
   input logic [ADDR_W-1:0]          dst_addr,
   input logic [DATA_W-1:0]          dst_data,
   input logic                       ld_busy,
   input logic                       ld_done,
   input logic [DATA_W-1:0]          pins_in,
   input logic [RW_COUNT*DATA_W-1:0] spr_out
);

   localparam logic [ADDR_W-1:0] PIN_A   = ADDR_W'(GP_WORDS);
   localparam logic [ADDR_W-1:0] CNT_A   = ADDR_W'(GP_WORDS + 1);
   localparam logic [ADDR_W-1:0] RW_BASE = ADDR_W'(GP_WORDS + RO_COUNT);

   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_PIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      src_addr == PIN_A |-> src_data == pins_in); // R3

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && src_addr == CNT_A && $past(src_addr) == CNT_A)
      |-> src_data == $past(src_data) + DATA_W'(1)); // R4

   AST_RW_SRC_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      src_addr >= RW_BASE |-> src_data == '0); // R5

   AST_RW_DST_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      dst_addr >= RW_BASE |-> dst_data == '0); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done |=> !ld_done); // R8

   AST_DONE_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done |-> (!ld_busy && $past(ld_busy))); // R8

   AST_LOAD_FREEZES_SPR: assert property (@(posedge clk) disable iff (!rst_n)
      ld_busy |=> $stable(spr_out)); // R9

endmodule

bind shadow_regfile shadow_regfile_chk #(
   .DATA_W    (DATA_W),
   .DEPTH     (DEPTH),
   .SPR_COUNT (SPR_COUNT),
   .RO_COUNT  (RO_COUNT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_addr (src_addr),
   .src_data (src_data),
   .dst_addr (dst_addr),
   .dst_data (dst_data),
   .ld_busy  (ld_busy),
   .ld_done  (ld_done),
   .pins_in  (pins_in),
   .spr_out  (spr_out)
);

// File: tb/shadow_regfile_tb.sv
module shadow_regfile_tb;

   localparam int CLK_PERIOD = 10;
   localparam int GP = 496;
   localparam int RWB = 504;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [8:0]   src_addr = '0, dst_addr = '0, fetch_addr = '0, wr_addr = '0;
   logic [31:0]  src_data, dst_data, fetch_data;
   logic         wr_en = 1'b0, ld_start = 1'b0, ld_valid = 1'b0;
   logic [31:0]  wr_data = '0, ld_data = '0, pins_in = '0;
   logic         ld_busy, ld_done;
   logic [255:0] spr_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   shadow_regfile u_dut (
      .clk(clk), .rst_n(rst_n),
      .src_addr(src_addr), .src_data(src_data),
      .dst_addr(dst_addr), .dst_data(dst_data),
      .fetch_addr(fetch_addr), .fetch_data(fetch_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ld_start(ld_start), .ld_valid(ld_valid), .ld_data(ld_data),
      .ld_busy(ld_busy), .ld_done(ld_done),
      .pins_in(pins_in), .spr_out(spr_out)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] m_mem [512];
   bit          m_known [512];
   logic [31:0] m_rw [8];
   logic [31:0] m_cnt;

   always @(posedge clk) begin
      if (!rst_n) m_cnt <= '0;
      else        m_cnt <= m_cnt + 32'd1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_src(input int a);
      if (a < GP) return m_mem[a];
      if (a == GP) return pins_in;
      if (a == GP + 1) return m_cnt;
      return 32'h0;
   endfunction

   function automatic logic [31:0] exp_dst(input int a);
      if (a >= RWB) return 32'h0;
      return m_mem[a];
   endfunction

   // Advance one clock: apply at posedge, return at the following negedge.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Core write of one word; the model is updated after the edge.
   task automatic core_write(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = 9'(a); wr_data = d;
      step();
      wr_en = 1'b0;
      m_mem[a] = d; m_known[a] = 1'b1;
      if (a >= RWB) m_rw[a - RWB] = d;
   endtask

   task automatic read_all(input string req, input int a);
      src_addr = 9'(a); dst_addr = 9'(a); fetch_addr = 9'(a);
      #1;
      if (a < GP || a == GP + 1 || (a > GP + 1)) chk({req, " src"}, src_data, exp_src(a));
      if (m_known[a] || a >= RWB) chk({req, " dst"}, dst_data, exp_dst(a));
      if (m_known[a]) chk({req, " fetch"}, fetch_data, m_mem[a]);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] c0, w5, w0, oldv, newv;
      void'($urandom(32'd20240917));
      for (int i = 0; i < 8; i++) m_rw[i] = '0;
      for (int i = 0; i < 512; i++) m_known[i] = 1'b0;

      // R11: reset values
      repeat (3) @(negedge clk);
      chk("R11 spr_out lo", spr_out[31:0], 32'h0);
      chk("R11 spr_out hi", spr_out[255:224], 32'h0);
      chk("R11 busy", {31'h0, ld_busy}, 32'h0);
      chk("R11 done", {31'h0, ld_done}, 32'h0);
      rst_n = 1'b1;
      step();

      // R8/R9: load with random gaps, core writes attempted in the gaps
      ld_start = 1'b1;
      step();
      ld_start = 1'b0;
      chk("R8 busy after start", {31'h0, ld_busy}, 32'h1);
      for (int i = 0; i < GP; i++) begin
         while ($urandom_range(3) == 0) begin
            ld_valid = 1'b0;
            wr_en = 1'b1; wr_data = $urandom();
            wr_addr = ($urandom_range(1) == 0) ? 9'd5 : 9'(RWB + 1);
            step();
            wr_en = 1'b0;
         end
         ld_valid = 1'b1; ld_data = $urandom();
         m_mem[i] = ld_data; m_known[i] = 1'b1;
         if (i == GP - 1) begin
            #1;
            chk("R8 busy on last beat", {31'h0, ld_busy}, 32'h1);
            chk("R8 no early done", {31'h0, ld_done}, 32'h0);
         end
         step();
      end
      ld_valid = 1'b0;
      chk("R8 done pulse", {31'h0, ld_done}, 32'h1);
      chk("R8 busy cleared", {31'h0, ld_busy}, 32'h0);
      step();
      chk("R8 done one cycle", {31'h0, ld_done}, 32'h0);
      chk("R9 spr_out untouched by blocked write", spr_out[63:32], 32'h0);
      read_all("R9 word 5 keeps loaded value", 5);
      read_all("R8 first loaded word", 0);
      read_all("R8 last loaded word", GP - 1);

      // R10: stray valid outside a load
      w0 = m_mem[0];
      ld_valid = 1'b1; ld_data = ~w0;
      step();
      ld_valid = 1'b0;
      chk("R10 busy stays low", {31'h0, ld_busy}, 32'h0);
      fetch_addr = 9'd0; #1;
      chk("R10 word 0 unchanged", fetch_data, w0);

      // R6/R3: shadow beneath read-only specials
      for (int a = GP; a < RWB; a++) core_write(a, $urandom());
      for (int a = GP; a < RWB; a++) begin
         pins_in = ~m_mem[a];
         read_all("R6 R3 read-only special", a);
      end
      pins_in = 32'h5a5a_0f0f;
      src_addr = 9'(GP); #1;
      chk("R3 pins live", src_data, 32'h5a5a_0f0f);
      src_addr = 9'(GP + 2); #1;
      chk("R5 spare reads zero", src_data, 32'h0);

      // R7/R5: control registers
      for (int a = RWB; a < 512; a++) core_write(a, $urandom());
      for (int a = RWB; a < 512; a++) begin
         read_all("R7 R5 control register", a);
         chk("R7 spr_out field", spr_out[(a-RWB)*32 +: 32], m_rw[a-RWB]);
      end

      // R2: same-cycle write and read
      oldv = m_mem[20]; newv = ~oldv;
      src_addr = 9'd20; dst_addr = 9'd20; fetch_addr = 9'd20;
      wr_en = 1'b1; wr_addr = 9'd20; wr_data = newv;
      #1;
      chk("R2 old on src", src_data, oldv);
      chk("R2 old on fetch", fetch_data, oldv);
      step();
      wr_en = 1'b0; m_mem[20] = newv;
      #1;
      chk("R2 new on dst", dst_data, newv);

      // R1: datum written by destination port later fetched
      core_write(100, 32'hC0DE_0001);
      fetch_addr = 9'd100; #1;
      chk("R1 write then fetch", fetch_data, 32'hC0DE_0001);

      // R4: counter step
      src_addr = 9'(GP + 1); #1;
      c0 = src_data;
      chk("R4 counter absolute", c0, m_cnt);
      repeat (5) step();
      #1;
      chk("R4 counter +5", src_data, c0 + 32'd5);

      // Random phase: R1 R2 R3 R5 R6 R7
      for (int n = 0; n < 3000; n++) begin
         int a, s, d, f;
         pins_in = $urandom();
         s = $urandom_range(511); d = $urandom_range(511); f = $urandom_range(511);
         src_addr = 9'(s); dst_addr = 9'(d); fetch_addr = 9'(f);
         #1;
         chk("R3 R4 R5 random src", src_data, exp_src(s));
         if (m_known[d] || d >= RWB) chk("R6 R7 random dst", dst_data, exp_dst(d));
         if (m_known[f]) chk("R1 R6 random fetch", fetch_data, m_mem[f]);
         if ($urandom_range(1) == 0) begin
            a = ($urandom_range(3) == 0) ? int'($urandom_range(511, GP)) : int'($urandom_range(511));
            core_write(a, $urandom());
            if (a >= RWB) chk("R7 random spr_out", spr_out[(a-RWB)*32 +: 32], m_rw[a-RWB]);
         end else begin
            step();
         end
      end

      // R9: second load, attempt a control write mid-load
      ld_start = 1'b1;
      step();
      ld_start = 1'b0;
      w5 = m_rw[0];
      wr_en = 1'b1; wr_addr = 9'(RWB); wr_data = ~w5;
      step();
      wr_en = 1'b0;
      chk("R9 control held during load", spr_out[31:0], w5);
      for (int i = 0; i < GP; i++) begin
         ld_valid = 1'b1; ld_data = $urandom();
         m_mem[i] = ld_data;
         step();
      end
      ld_valid = 1'b0;
      chk("R8 second done", {31'h0, ld_done}, 32'h1);
      read_all("R10 specials untouched by load", RWB - 1);
      read_all("R8 reload word", 77);

      finish_run();
   end

endmodule